// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Clock Division

This block is a bus-mapped watchdog. A programmable prescaler divides the bus clock by a value from 1 to 256. A second stage then divides that rate by 16, 32, 64 or 128, chosen by a 2-bit select field. Each resulting tick steps a 16-bit down-counter. When the counter is found at zero on a tick, it reloads from a reload register and raises an expiry event. If the timer is enabled and reset generation is also enabled, that event produces a one-cycle reset request.

Software keeps the system alive by writing the counter register before it runs out. The same write restarts the division chain, so the next expiry always comes a full, predictable time later.

The reload register is locked while either the enable bit or the reset-enable bit is set. Software must disarm the timer fully before it can change the period. An optional interrupt flag is raised on every expiry and is cleared by writing any value to a dedicated clear address.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0x0000_8021, the counter reads 0x0000_8000, the reload register reads 0x0000_8000, and both irq_o and rst_req_o are low.
- R2: Control field positions are: prescaler [15:8], run enable bit 5, select [4:3], interrupt enable bit 2, reset enable bit 0. All other bits read as zero, so writing all ones reads back 0x0000_FF3D.
- R3: With prescaler P and select S, a tick occurs every (P+1)·2^(4+S) clock cycles while run enable is set. No tick occurs while it is clear.
- R4: A write to offset 0x8 loads the counter directly from wdata[15:0] and clears both division stages. A counter loaded with N then expires on the (N+1)-th tick, which is (N+1)·(P+1)·2^(4+S) cycles after counting starts.
- R5: rst_req_o is high for exactly one cycle. It rises on the clock edge after an expiry, and only if run enable and reset enable were both set. Expiries with reset enable clear never raise it.
- R6: A write to the reload register (offset 0x4) is accepted only while run enable and reset enable are both clear. Otherwise the stored value is unchanged.
- R7: On expiry the counter takes the reload value in the same clock edge.
- R8: Clearing run enable freezes the prescaler, the second stage and the counter at their current values. Setting it again resumes from those values.
- R9: If interrupt enable is set, an expiry sets irq_o on the same edge. A write of any value to offset 0xC clears it.
- R10: Writing 0 to control, then 1 to the counter, then 0x21 to control (run and reset enable, P=0, S=0) raises rst_req_o 32 cycles after the control write.
- R11: Rewriting the counter more often than the expiry time prevents any reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | Write qualifier for the access |
| addr_i | input | 4 | Byte offset: 0x0 control, 0x4 reload, 0x8 counter, 0xC interrupt clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Expiry interrupt flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Register writes take effect on the clock edge where sel_i and wr_i are sampled, and reads are combinational. The bench therefore drives on the falling edge and reads back half a cycle after the write edge.

The reset request is due (N+1)·(P+1)·2^(4+S) edges after the enabling control write, and it goes low one edge later. The counter reload and the interrupt flag appear on the tick edge itself. The bench counts falling edges from the write edge and samples each result exactly at the edge where it is due.

The freeze check uses a partly advanced second stage. This shows that resuming keeps the partial count: the next tick arrives after 6 cycles, not 16.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFS_CTRL = 32'h0;
  localparam int unsigned OFS_RLD  = 32'h4;
  localparam int unsigned OFS_CNT  = 32'h8;
  localparam int unsigned OFS_ICLR = 32'hC;

  localparam int unsigned RSTEN_BIT = 0;
  localparam int unsigned INTEN_BIT = 2;
  localparam int unsigned SEL_LSB   = 3;
  localparam int unsigned RUN_BIT   = 5;
  localparam int unsigned PRE_LSB   = 8;

  localparam int unsigned BASE_DIV_LOG2 = 4;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic              rst_en_o,
  output logic              int_en_o,
  output logic [PRE_W-1:0]  presc_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              rld_wr_o,
  output logic              clr_wr_o
);
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(1) << (PRE_W - 1);
  localparam logic [CNT_W-1:0] RLD_RST = CNT_W'(1) << (CNT_W - 1);

  logic wr_en, ctrl_hit, rld_hit, cnt_hit, clr_hit;

  assign wr_en    = sel_i && wr_i;
  assign ctrl_hit = addr_i == ADDR_W'(OFS_CTRL);
  assign rld_hit  = addr_i == ADDR_W'(OFS_RLD);
  assign cnt_hit  = addr_i == ADDR_W'(OFS_CNT);
  assign clr_hit  = addr_i == ADDR_W'(OFS_ICLR);

  assign cnt_wr_o    = wr_en && cnt_hit;
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];
  assign rld_wr_o    = wr_en && rld_hit;
  assign clr_wr_o    = wr_en && clr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b1;
      rst_en_o <= 1'b1;
      int_en_o <= 1'b0;
      sel_o    <= '0;
      presc_o  <= PRE_RST;
    end else if (wr_en && ctrl_hit) begin
      run_o    <= wdata_i[RUN_BIT];
      rst_en_o <= wdata_i[RSTEN_BIT];
      int_en_o <= wdata_i[INTEN_BIT];
      sel_o    <= wdata_i[SEL_LSB +: SEL_W];
      presc_o  <= wdata_i[PRE_LSB +: PRE_W];
    end
  end

  // reload is locked unless fully disarmed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_o <= RLD_RST;
    end else if (rld_wr_o && !run_o && !rst_en_o) begin
      reload_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[RUN_BIT]               = run_o;
      rdata_o[RSTEN_BIT]             = rst_en_o;
      rdata_o[INTEN_BIT]             = int_en_o;
      rdata_o[SEL_LSB +: SEL_W]      = sel_o;
      rdata_o[PRE_LSB +: PRE_W]      = presc_o;
    end else if (rld_hit) begin
      rdata_o[CNT_W-1:0] = reload_o;
    end else if (cnt_hit) begin
      rdata_o[CNT_W-1:0] = cnt_i;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = BASE_DIV_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             pre_tick;

  assign pre_tick = run_i && (pre_q == presc_i);

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = i < (BASE_DIV_LOG2 + int'(sel_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (restart_i) begin
      pre_q <= '0;
    end else if (run_i) begin
      pre_q <= pre_tick ? '0 : pre_q + 1'b1;
    end
  end

  // power-of-two stage: free-running, masked compare picks the ratio
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (restart_i) begin
      div_q <= '0;
    end else if (pre_tick) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = pre_tick && ((div_q & mask) == mask) && !restart_i;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1) << (CNT_W - 1);

  assign expire_o = tick_i && !load_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= CNT_RST;
    end else if (load_i) begin
      cnt_o <= load_val_i;
    end else if (expire_o) begin
      cnt_o <= reload_i;
    end else if (tick_i) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             run_w, rst_en_w, int_en_w;
  logic [PRE_W-1:0] presc_w;
  logic [SEL_W-1:0] sel_w;
  logic [CNT_W-1:0] reload_w, cnt_w, cnt_wdata_w;
  logic             cnt_wr_w, rld_wr_w, clr_wr_w;
  logic             tick_w, expire_w;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_w),
    .rdata_o    (rdata_o),
    .run_o      (run_w),
    .rst_en_o   (rst_en_w),
    .int_en_o   (int_en_w),
    .presc_o    (presc_w),
    .sel_o      (sel_w),
    .reload_o   (reload_w),
    .cnt_wr_o   (cnt_wr_w),
    .cnt_wdata_o(cnt_wdata_w),
    .rld_wr_o   (rld_wr_w),
    .clr_wr_o   (clr_wr_w)
  );

  wdog_divider #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .restart_i(cnt_wr_w),
    .presc_i  (presc_w),
    .sel_i    (sel_w),
    .tick_o   (tick_w)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_wr_w),
    .load_val_i(cnt_wdata_w),
    .tick_i    (tick_w),
    .reload_i  (reload_w),
    .cnt_o     (cnt_w),
    .expire_o  (expire_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire_w && run_w && rst_en_w;
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
    end else if (expire_w && int_en_w) begin
      irq_o <= 1'b1;
    end else if (clr_wr_w) begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             rst_en_i,
  input logic             tick_i,
  input logic             expire_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             cnt_wr_i,
  input logic             rld_wr_i,
  input logic             clr_wr_i,
  input logic             irq_i,
  input logic             rst_req_i
);
  assert_no_tick_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_i);

  assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i);

  assert_pulse_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(run_i && rst_en_i && expire_i));

  assert_reload_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_wr_i && (run_i || rst_en_i)) |=> $stable(reload_i));

  assert_expire_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (cnt_i == $past(reload_i)));

  assert_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_i));

  assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !expire_i) |=> !irq_i);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_w),
  .rst_en_i (rst_en_w),
  .tick_i   (tick_w),
  .expire_i (expire_w),
  .cnt_i    (cnt_w),
  .reload_i (reload_w),
  .cnt_wr_i (cnt_wr_w),
  .rld_wr_i (rld_wr_w),
  .clr_wr_i (clr_wr_w),
  .irq_i    (irq_o),
  .rst_req_i(rst_req_o)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  typedef struct packed {
    logic [7:0]  p;
    logic [1:0]  s;
    logic [15:0] n;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{p: 8'd0, s: 2'd0, n: 16'd0},
    '{p: 8'd0, s: 2'd0, n: 16'd1},
    '{p: 8'd1, s: 2'd0, n: 16'd0},
    '{p: 8'd0, s: 2'd1, n: 16'd0},
    '{p: 8'd0, s: 2'd2, n: 16'd1},
    '{p: 8'd2, s: 2'd3, n: 16'd0},
    '{p: 8'd1, s: 2'd1, n: 16'd2},
    '{p: 8'd0, s: 2'd3, n: 16'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdog_timer dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sel_i    (sel),
    .wr_i     (wr),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .irq_o    (irq),
    .rst_req_o(rst_req)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; sel = 1'b1; wr = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; sel = 1'b1; wr = 1'b0;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic wait_pulse(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (rst_req) begin
        k = i;
        break;
      end
    end
  endtask

  logic [31:0] rd;
  int          got, expc;
  bit          seen;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, rd); chk("R1 ctrl", rd, 32'h8021);
    bus_rd(4'h8, rd); chk("R1 counter", rd, 32'h8000);
    bus_rd(4'h4, rd); chk("R1 reload", rd, 32'h8000);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);

    // R6 reload lock
    bus_wr(4'h4, 32'h1234);
    bus_rd(4'h4, rd); chk("R6 armed write ignored", rd, 32'h8000);
    bus_wr(4'h0, 32'h20);
    bus_wr(4'h4, 32'h1234);
    bus_rd(4'h4, rd); chk("R6 run-only write ignored", rd, 32'h8000);
    bus_wr(4'h0, 32'h01);
    bus_wr(4'h4, 32'h1234);
    bus_rd(4'h4, rd); chk("R6 rst-en-only write ignored", rd, 32'h8000);
    bus_wr(4'h0, 32'h00);
    bus_wr(4'h4, 32'h1234);
    bus_rd(4'h4, rd); chk("R6 disarmed write taken", rd, 32'h1234);

    // R2 field layout
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, rd); chk("R2 ctrl readback", rd, 32'h0000_FF3D);
    bus_wr(4'h0, 32'h0);

    // R3 R4 R5 vector walk
    foreach (VECS[v]) begin
      bus_wr(4'h0, 32'h0);
      bus_wr(4'h8, {16'd0, VECS[v].n});
      bus_wr(4'h0, {16'd0, VECS[v].p, 3'b001, VECS[v].s, 3'b001});
      expc = (int'(VECS[v].n) + 1) * (int'(VECS[v].p) + 1) * (16 << VECS[v].s);
      wait_pulse(2000, got);
      chk($sformatf("R3 R4 vec%0d expiry cycle", v), got, expc);
      @(negedge clk);
      chk($sformatf("R5 vec%0d single pulse", v), {31'd0, rst_req}, 32'd0);
    end

    // R10 quick reset sequence
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h8, 32'h1);
    bus_wr(4'h0, 32'h21);
    wait_pulse(200, got);
    chk("R10 quick reset cycle", got, 32);

    // R8 freeze and resume
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h8, 32'h5);
    bus_wr(4'h0, 32'h20);
    repeat (40) @(negedge clk);
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h8, rd); chk("R8 count at freeze", rd, 32'h3);
    repeat (100) @(negedge clk);
    bus_rd(4'h8, rd); chk("R8 count held", rd, 32'h3);
    bus_wr(4'h0, 32'h20);
    repeat (5) @(negedge clk);
    bus_rd(4'h8, rd); chk("R8 no tick before partial stage done", rd, 32'h3);
    @(negedge clk);
    bus_rd(4'h8, rd); chk("R8 resumed tick keeps partial count", rd, 32'h2);

    // R7 R9 R5 expiry without reset enable
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h4, 32'h7);
    bus_wr(4'h8, 32'h0);
    bus_wr(4'h0, 32'h24);
    repeat (15) @(negedge clk);
    chk("R9 irq before expiry", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R9 irq on expiry", {31'd0, irq}, 32'd1);
    bus_rd(4'h8, rd); chk("R7 reload on expiry", rd, 32'h7);
    seen = rst_req;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    chk("R5 no request without reset enable", {31'd0, seen}, 32'd0);
    chk("R9 irq held", {31'd0, irq}, 32'd1);
    bus_wr(4'hC, 32'hA5);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);

    // R11 servicing
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h8, 32'h3);
    bus_wr(4'h0, 32'h21);
    seen = 1'b0;
    for (int j = 0; j < 10; j++) begin
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (rst_req) seen = 1'b1;
      end
      bus_wr(4'h8, 32'h3);
      if (rst_req) seen = 1'b1;
    end
    chk("R11 serviced no request", {31'd0, seen}, 32'd0);
    wait_pulse(200, got);
    chk("R4 R11 expiry after last service", got, 64);

    finish_run();
  end
endmodule